// File: doc/BRIEF.md
# Fault Group Spare-Bound Early Terminator

This block sits after a memory test and must-repair allocation. It receives the remaining faulty cells of one memory, each as a row and column address, one per cycle. On a run request it splits the faults into independent groups, where a group is a set of faults linked through shared rows or shared columns. It then derives a lower bound on the number of spare lines each group needs. If the bounds add up to more than the row and column spares still free, the memory cannot be repaired, and the block flags this so that further repair analysis can be skipped.

Each group's bound comes from four counts: the distinct faulty rows and columns in the group, and the rows and columns that hold two or more of its faults. The bound is therefore tighter than simply charging one spare per group. The block produces no repair solution. It reports only the group count and the go/no-go flag, as a single-cycle completion pulse.

Top module: `fault_group_terminator`

## Requirements
- R1: After reset, `busy`, `done` and `unrepairable` are low and `groupCount` is zero.
- R2: A pulse on `faultValid` while idle appends one fault to the list. Only the first MAX_FAULTS (default 8) faults since the last clear are kept, and any further fault is ignored.
- R3: `groupCount` equals the number of groups, where two stored faults belong to the same group when a chain of faults links them and each adjacent pair in the chain shares a row address or a column address.
- R4: A group with no multi-fault row or no multi-fault column needs exactly one spare. A multi-fault line is one that holds at least two faults of the group.
- R5: When a group has fewer multi-fault rows (m) than multi-fault columns, it needs m spares if all of its faulty rows are multi-fault rows, and m+1 spares otherwise. When it has fewer multi-fault columns, the same rule applies with columns in place of rows.
- R6: When a group's multi-fault row and column counts are equal and nonzero, the rule in R5 is applied in both directions and the smaller result is taken.
- R7: `unrepairable` is high exactly when the sum of all group needs is strictly greater than `spareRows + spareCols`. The spare values used are the ones sampled in the cycle that starts the run.
- R8: A run request accepted while idle raises `busy` from the next cycle. `done` is later high for exactly one cycle, with `busy` low and the results valid in that cycle. The results are then held until the next completion.
- R9: A pulse on `listClear` while idle empties the list. `faultValid`, `listClear` and `runReq` have no effect while `busy` is high.
- R10: A run on an empty list reports zero groups and a low `unrepairable`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| listClear | input | 1 | Empty the fault list (idle only) |
| faultValid | input | 1 | Append the fault on faultRow/faultCol (idle only) |
| faultRow | input | ROW_W | Row address of the fault |
| faultCol | input | COL_W | Column address of the fault |
| spareRows | input | SPARE_W | Spare rows left after must-repair |
| spareCols | input | SPARE_W | Spare columns left after must-repair |
| runReq | input | 1 | Start grouping and evaluation |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle completion pulse |
| unrepairable | output | 1 | Sum of group needs exceeds free spares |
| groupCount | output | $clog2(MAX_FAULTS+1) | Number of fault groups found |

## Verification
On every cycle the assertions check the handshake: a run starts `busy`, `done` lasts exactly one cycle and never coincides with `busy`, a group count larger than the spares sampled at the run start always comes with the flag set, and an empty result never sets the flag. The per-group spare bound cannot be checked that way, because it depends on how faults chain through shared lines. The bench therefore checks it on hand-built shapes (single faults, lines, L-shapes, squares, and row-heavy and column-heavy clusters) and on hundreds of pseudo-random dense fault sets. Each set is run at a spare total one below the expected need and at exactly the expected need, so that the strict comparison is tested at its edge.

// File: rtl/fgt_pkg.sv
package fgt_pkg;

  typedef struct packed {
    logic clearList;
    logic loadFault;
    logic initLabels;
    logic stepLabels;
    logic latchResult;
  } fgtStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PROP = 2'd1,
    ST_STAT = 2'd2
  } fgtState_t;

  // Lower bound on spares for one group from its line counts (R4, R5, R6)
  function automatic int unsigned groupNeed(input int unsigned nfr, input int unsigned nfc,
                                            input int unsigned nmr, input int unsigned nmc);
    int unsigned rowWay;
    int unsigned colWay;
    rowWay = (nfr == nmr) ? nmr : nmr + 1;
    colWay = (nfc == nmc) ? nmc : nmc + 1;
    if (nmr == 0 || nmc == 0) return 1;
    if (nmr < nmc) return rowWay;
    if (nmc < nmr) return colWay;
    return (rowWay < colWay) ? rowWay : colWay;
  endfunction

endpackage

// File: rtl/fgt_control.sv
module fgt_control
  import fgt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        listClear,
  input  logic        faultValid,
  input  logic        runReq,
  input  logic        propChanged,
  output fgtStrobes_t strobes,
  output logic        busy
);

  fgtState_t stateQ, stateD;

  always_comb begin
    stateD  = stateQ;
    strobes = '0;
    unique case (stateQ)
      ST_IDLE: begin
        strobes.clearList = listClear;
        strobes.loadFault = faultValid && !listClear;
        if (runReq) begin
          strobes.initLabels = 1'b1;
          stateD = ST_PROP;
        end
      end
      ST_PROP: begin
        strobes.stepLabels = 1'b1;
        if (!propChanged) stateD = ST_STAT;
      end
      ST_STAT: begin
        strobes.latchResult = 1'b1;
        stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign busy = (stateQ != ST_IDLE);

endmodule

// File: rtl/fgt_datapath.sv
module fgt_datapath
  import fgt_pkg::*;
#(
  parameter int MAX_FAULTS = 8,
  parameter int ROW_W      = 4,
  parameter int COL_W      = 4,
  parameter int SPARE_W    = 4
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  fgtStrobes_t                       strobes,
  input  logic [ROW_W-1:0]                  faultRow,
  input  logic [COL_W-1:0]                  faultCol,
  input  logic [SPARE_W-1:0]                spareRows,
  input  logic [SPARE_W-1:0]                spareCols,
  output logic                              propChanged,
  output logic                              done,
  output logic                              unrepairable,
  output logic [$clog2(MAX_FAULTS+1)-1:0]   groupCount
);

  localparam int IDX_W   = (MAX_FAULTS > 1) ? $clog2(MAX_FAULTS) : 1;
  localparam int CNT_W   = $clog2(MAX_FAULTS + 1);
  localparam int AVAIL_W = SPARE_W + 1;
  localparam int CMP_W   = ((CNT_W > AVAIL_W) ? CNT_W : AVAIL_W) + 1;

  logic [ROW_W-1:0]   rowMem    [MAX_FAULTS];
  logic [COL_W-1:0]   colMem    [MAX_FAULTS];
  logic [IDX_W-1:0]   labelQ    [MAX_FAULTS];
  logic [IDX_W-1:0]   labelNext [MAX_FAULTS];
  logic [CNT_W-1:0]   cntQ;
  logic [AVAIL_W-1:0] availQ;
  logic               doneQ, unrepQ;
  logic [CNT_W-1:0]   groupsQ;

  logic [MAX_FAULTS-1:0] validVec;
  logic [MAX_FAULTS-1:0] adj       [MAX_FAULTS];
  logic [MAX_FAULTS-1:0] inGrp     [MAX_FAULTS];
  logic [MAX_FAULTS-1:0] firstRow  [MAX_FAULTS];
  logic [MAX_FAULTS-1:0] laterRow  [MAX_FAULTS];
  logic [MAX_FAULTS-1:0] firstCol  [MAX_FAULTS];
  logic [MAX_FAULTS-1:0] laterCol  [MAX_FAULTS];
  logic [MAX_FAULTS-1:0] isRep;
  logic [CNT_W-1:0]      nfrG [MAX_FAULTS];
  logic [CNT_W-1:0]      nfcG [MAX_FAULTS];
  logic [CNT_W-1:0]      nmrG [MAX_FAULTS];
  logic [CNT_W-1:0]      nmcG [MAX_FAULTS];
  logic [CMP_W-1:0]      sumAll;
  logic [CNT_W-1:0]      groupsAll;

  // Stored entries and their line adjacency
  always_comb begin
    for (int i = 0; i < MAX_FAULTS; i++) begin
      validVec[i] = (CNT_W'(i) < cntQ);
    end
    for (int i = 0; i < MAX_FAULTS; i++) begin
      for (int j = 0; j < MAX_FAULTS; j++) begin
        adj[i][j] = validVec[i] && validVec[j] &&
                    ((rowMem[i] == rowMem[j]) || (colMem[i] == colMem[j]));
      end
    end
  end

  // One label propagation pass: take the smallest neighbour label
  always_comb begin
    propChanged = 1'b0;
    for (int i = 0; i < MAX_FAULTS; i++) begin
      labelNext[i] = labelQ[i];
      for (int j = 0; j < MAX_FAULTS; j++) begin
        if (adj[i][j] && (labelQ[j] < labelNext[i])) labelNext[i] = labelQ[j];
      end
      if (labelNext[i] != labelQ[i]) propChanged = 1'b1;
    end
  end

  // Per-group line statistics, indexed by the group's lowest fault index
  always_comb begin
    for (int g = 0; g < MAX_FAULTS; g++) begin
      isRep[g] = validVec[g] && (labelQ[g] == IDX_W'(g));
      for (int j = 0; j < MAX_FAULTS; j++) begin
        inGrp[g][j] = validVec[j] && (labelQ[j] == IDX_W'(g));
      end
    end
    for (int g = 0; g < MAX_FAULTS; g++) begin
      for (int j = 0; j < MAX_FAULTS; j++) begin
        firstRow[g][j] = inGrp[g][j];
        firstCol[g][j] = inGrp[g][j];
        laterRow[g][j] = 1'b0;
        laterCol[g][j] = 1'b0;
        for (int k = 0; k < MAX_FAULTS; k++) begin
          if (inGrp[g][k] && (k < j) && (rowMem[k] == rowMem[j])) firstRow[g][j] = 1'b0;
          if (inGrp[g][k] && (k < j) && (colMem[k] == colMem[j])) firstCol[g][j] = 1'b0;
          if (inGrp[g][k] && (k > j) && (rowMem[k] == rowMem[j])) laterRow[g][j] = 1'b1;
          if (inGrp[g][k] && (k > j) && (colMem[k] == colMem[j])) laterCol[g][j] = 1'b1;
        end
      end
      nfrG[g] = CNT_W'($countones(firstRow[g]));
      nfcG[g] = CNT_W'($countones(firstCol[g]));
      nmrG[g] = CNT_W'($countones(firstRow[g] & laterRow[g]));
      nmcG[g] = CNT_W'($countones(firstCol[g] & laterCol[g]));
    end
  end

  // Sum of group bounds
  always_comb begin
    sumAll    = '0;
    groupsAll = '0;
    for (int g = 0; g < MAX_FAULTS; g++) begin
      if (isRep[g]) begin
        sumAll = sumAll + CMP_W'(groupNeed(32'(nfrG[g]), 32'(nfcG[g]),
                                           32'(nmrG[g]), 32'(nmcG[g])));
        groupsAll = groupsAll + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ    <= '0;
      availQ  <= '0;
      doneQ   <= 1'b0;
      unrepQ  <= 1'b0;
      groupsQ <= '0;
      for (int i = 0; i < MAX_FAULTS; i++) begin
        rowMem[i] <= '0;
        colMem[i] <= '0;
        labelQ[i] <= '0;
      end
    end else begin
      doneQ <= 1'b0;
      if (strobes.clearList) cntQ <= '0;
      if (strobes.loadFault && (cntQ < CNT_W'(MAX_FAULTS))) begin
        for (int i = 0; i < MAX_FAULTS; i++) begin
          if (CNT_W'(i) == cntQ) begin
            rowMem[i] <= faultRow;
            colMem[i] <= faultCol;
          end
        end
        cntQ <= cntQ + CNT_W'(1);
      end
      if (strobes.initLabels) begin
        for (int i = 0; i < MAX_FAULTS; i++) labelQ[i] <= IDX_W'(i);
        availQ <= AVAIL_W'(spareRows) + AVAIL_W'(spareCols);
      end
      if (strobes.stepLabels) begin
        for (int i = 0; i < MAX_FAULTS; i++) labelQ[i] <= labelNext[i];
      end
      if (strobes.latchResult) begin
        doneQ   <= 1'b1;
        groupsQ <= groupsAll;
        unrepQ  <= (sumAll > CMP_W'(availQ));
      end
    end
  end

  assign done         = doneQ;
  assign unrepairable = unrepQ;
  assign groupCount   = groupsQ;

endmodule

// File: rtl/fault_group_terminator.sv
module fault_group_terminator
  import fgt_pkg::*;
#(
  parameter int MAX_FAULTS = 8,
  parameter int ROW_W      = 4,
  parameter int COL_W      = 4,
  parameter int SPARE_W    = 4
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            listClear,
  input  logic                            faultValid,
  input  logic [ROW_W-1:0]                faultRow,
  input  logic [COL_W-1:0]                faultCol,
  input  logic [SPARE_W-1:0]              spareRows,
  input  logic [SPARE_W-1:0]              spareCols,
  input  logic                            runReq,
  output logic                            busy,
  output logic                            done,
  output logic                            unrepairable,
  output logic [$clog2(MAX_FAULTS+1)-1:0] groupCount
);

  fgtStrobes_t strobes;
  logic        propChanged;

  fgt_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .listClear  (listClear),
    .faultValid (faultValid),
    .runReq     (runReq),
    .propChanged(propChanged),
    .strobes    (strobes),
    .busy       (busy)
  );

  fgt_datapath #(
    .MAX_FAULTS(MAX_FAULTS),
    .ROW_W     (ROW_W),
    .COL_W     (COL_W),
    .SPARE_W   (SPARE_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .faultRow    (faultRow),
    .faultCol    (faultCol),
    .spareRows   (spareRows),
    .spareCols   (spareCols),
    .propChanged (propChanged),
    .done        (done),
    .unrepairable(unrepairable),
    .groupCount  (groupCount)
  );

endmodule

// File: rtl/fgt_checker.sv
module fgt_checker #(
  parameter int MAX_FAULTS = 8,
  parameter int ROW_W      = 4,
  parameter int COL_W      = 4,
  parameter int SPARE_W    = 4
) (
  input logic                            clk,
  input logic                            rstN,
  input logic                            runReq,
  input logic [SPARE_W-1:0]              spareRows,
  input logic [SPARE_W-1:0]              spareCols,
  input logic                            busy,
  input logic                            done,
  input logic                            unrepairable,
  input logic [$clog2(MAX_FAULTS+1)-1:0] groupCount
);

  localparam int CNT_W   = $clog2(MAX_FAULTS + 1);
  localparam int AVAIL_W = SPARE_W + 1;
  localparam int CMP_W   = ((CNT_W > AVAIL_W) ? CNT_W : AVAIL_W) + 1;

  logic [AVAIL_W-1:0] availTrk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) availTrk <= '0;
    else if (runReq && !busy) availTrk <= AVAIL_W'(spareRows) + AVAIL_W'(spareCols);
  end

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  p_run_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    (runReq && !busy) |=> busy);

  // Each group needs at least one spare, so more groups than spares is fatal
  p_group_excess_r7: assert property (@(posedge clk) disable iff (!rstN)
    (done && (CMP_W'(groupCount) > CMP_W'(availTrk))) |-> unrepairable);

  p_empty_ok_r10: assert property (@(posedge clk) disable iff (!rstN)
    (done && (groupCount == '0)) |-> !unrepairable);

endmodule

bind fault_group_terminator fgt_checker #(
  .MAX_FAULTS(MAX_FAULTS),
  .ROW_W     (ROW_W),
  .COL_W     (COL_W),
  .SPARE_W   (SPARE_W)
) u_fgt_checker (
  .clk         (clk),
  .rstN        (rstN),
  .runReq      (runReq),
  .spareRows   (spareRows),
  .spareCols   (spareCols),
  .busy        (busy),
  .done        (done),
  .unrepairable(unrepairable),
  .groupCount  (groupCount)
);

// File: tb/tb_fault_group_terminator.sv
module tb_fault_group_terminator;

  localparam int MAXF = 8;
  localparam int RW   = 4;
  localparam int CW   = 4;
  localparam int SW   = 4;
  localparam int GW   = $clog2(MAXF + 1);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          listClear = 1'b0;
  logic          faultValid = 1'b0;
  logic [RW-1:0] faultRow = '0;
  logic [CW-1:0] faultCol = '0;
  logic [SW-1:0] spareRows = '0;
  logic [SW-1:0] spareCols = '0;
  logic          runReq = 1'b0;
  logic          busy, done, unrepairable;
  logic [GW-1:0] groupCount;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  int rRow [MAXF];
  int rCol [MAXF];
  int rN = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  fault_group_terminator #(.MAX_FAULTS(MAXF), .ROW_W(RW), .COL_W(CW), .SPARE_W(SW)) dut (
    .clk(clk), .rstN(rstN), .listClear(listClear), .faultValid(faultValid),
    .faultRow(faultRow), .faultCol(faultCol), .spareRows(spareRows), .spareCols(spareCols),
    .runReq(runReq), .busy(busy), .done(done), .unrepairable(unrepairable),
    .groupCount(groupCount));

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Spare bound per requirements R4, R5, R6
  function automatic int needOf(input int nfr, input int nfc, input int nmr, input int nmc);
    int a, b;
    if (nmr == 0 || nmc == 0) return 1;
    a = (nfr > nmr) ? nmr + 1 : nmr;
    b = (nfc > nmc) ? nmc + 1 : nmc;
    if (nmr < nmc) return a;
    if (nmc < nmr) return b;
    return (a < b) ? a : b;
  endfunction

  task automatic model(output int groups, output int total);
    int lab [MAXF];
    groups = 0;
    total  = 0;
    for (int i = 0; i < rN; i++) lab[i] = i;
    for (int p = 0; p < MAXF; p++)
      for (int i = 0; i < rN; i++)
        for (int j = 0; j < rN; j++)
          if ((rRow[i] == rRow[j] || rCol[i] == rCol[j]) && lab[j] < lab[i]) lab[i] = lab[j];
    for (int g = 0; g < rN; g++) begin
      int nfr, nfc, nmr, nmc;
      if (lab[g] != g) continue;
      groups++;
      nfr = 0; nfc = 0; nmr = 0; nmc = 0;
      for (int j = 0; j < rN; j++) begin
        int rc, cc;
        bit fr, fc;
        if (lab[j] != g) continue;
        rc = 0; cc = 0; fr = 1; fc = 1;
        for (int k = 0; k < rN; k++) begin
          if (lab[k] != g) continue;
          if (rRow[k] == rRow[j]) begin rc++; if (k < j) fr = 0; end
          if (rCol[k] == rCol[j]) begin cc++; if (k < j) fc = 0; end
        end
        if (fr) begin nfr++; if (rc >= 2) nmr++; end
        if (fc) begin nfc++; if (cc >= 2) nmc++; end
      end
      total += needOf(nfr, nfc, nmr, nmc);
    end
  endtask

  task automatic clearList();
    listClear = 1'b1;
    @(negedge clk);
    listClear = 1'b0;
    rN = 0;
  endtask

  task automatic addFault(input int r, input int c);
    faultValid = 1'b1;
    faultRow = RW'(r);
    faultCol = CW'(c);
    @(negedge clk);
    faultValid = 1'b0;
    if (rN < MAXF) begin
      rRow[rN] = r;
      rCol[rN] = c;
      rN++;
    end
  endtask

  task automatic waitDone(input string tag);
    bit seen = 0;
    for (int w = 0; w < 100; w++) begin
      @(negedge clk);
      if (done) begin seen = 1; break; end
    end
    check({tag, " done pulse"}, int'(seen), 1);
    if (seen) begin
      check("R8 busy low at done", int'(busy), 0);
    end
  endtask

  task automatic runCheck(input int total, input int expGroups, input int expUnrep, input string tag);
    spareRows = SW'(total / 2);
    spareCols = SW'(total - total / 2);
    runReq = 1'b1;
    @(negedge clk);
    runReq = 1'b0;
    check("R8 busy after run", int'(busy), 1);
    waitDone(tag);
    check("R3 group count", int'(groupCount), expGroups);
    check(tag, int'(unrepairable), expUnrep);
    @(negedge clk);
    check("R8 done one cycle", int'(done), 0);
  endtask

  // Loads nothing new; runs at need-1 and need
  task automatic edgePair(input int need, input int groups, input string tag);
    if (need > 0) runCheck(need - 1, groups, 1, tag);
    runCheck(need, groups, 0, tag);
  endtask

  initial begin
    int g, s;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 unrepairable", int'(unrepairable), 0);
    check("R1 groupCount", int'(groupCount), 0);

    // R10: empty list
    clearList();
    runCheck(0, 0, 0, "R10 empty list");

    // R4: single fault and a line of three
    addFault(3, 3);
    edgePair(1, 1, "R4 single fault");
    clearList();
    addFault(2, 1); addFault(2, 5); addFault(2, 9);
    edgePair(1, 1, "R4 row line");
    // R6: L shape -> 2, square -> 2
    clearList();
    addFault(0, 0); addFault(0, 1); addFault(1, 0);
    edgePair(2, 1, "R6 L shape");
    clearList();
    addFault(0, 0); addFault(0, 1); addFault(1, 0); addFault(1, 1);
    edgePair(2, 1, "R6 square");
    // R5: row criterion with a lone row -> 2
    clearList();
    addFault(0, 0); addFault(0, 1); addFault(0, 2); addFault(1, 0); addFault(2, 1);
    edgePair(2, 1, "R5 row plus one");
    // R5: column mirror -> 2
    clearList();
    addFault(0, 0); addFault(1, 0); addFault(2, 0); addFault(0, 1); addFault(1, 2);
    edgePair(2, 1, "R5 column plus one");
    // R5: all rows multi, fewer than multi columns -> 2
    clearList();
    addFault(0, 0); addFault(0, 1); addFault(0, 2); addFault(1, 0); addFault(1, 1); addFault(1, 2);
    edgePair(2, 1, "R5 rows exact");
    // R3: chain linking via shared lines, plus a separate fault
    clearList();
    addFault(0, 0); addFault(5, 5); addFault(0, 3); addFault(4, 3); addFault(4, 7);
    model(g, s);
    check("R3 chain model groups", g, 2);
    edgePair(s, 2, "R7 chain");

    // R2: ten isolated faults, only eight kept
    clearList();
    for (int i = 0; i < 10; i++) addFault(i, i);
    edgePair(MAXF, MAXF, "R2 overflow ignored");

    // R9: faultValid, listClear and runReq during busy are ignored
    clearList();
    addFault(1, 1); addFault(1, 2);
    spareRows = '0; spareCols = SW'(1);
    runReq = 1'b1;
    @(negedge clk);
    runReq = 1'b0;
    faultValid = 1'b1; faultRow = RW'(9); faultCol = CW'(9);
    listClear = 1'b1;
    runReq = 1'b1;
    @(negedge clk);
    faultValid = 1'b0; listClear = 1'b0; runReq = 1'b0;
    waitDone("R9 busy run");
    check("R9 groups after busy input", int'(groupCount), 1);
    @(negedge clk);
    runCheck(1, 1, 0, "R9 list unchanged");

    // R9: clear while idle empties the list
    clearList();
    runCheck(0, 0, 0, "R9 clear idle");

    // R7 sweep over dense pseudo-random fault sets
    for (int p = 0; p < 400; p++) begin
      int n;
      clearList();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      n = 1 + int'(lfsr[2:0]);
      for (int f = 0; f < n; f++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        addFault(int'(lfsr[3:0]) % 5, int'(lfsr[11:8]) % 5);
      end
      model(g, s);
      edgePair(s, g, "R7 sweep");
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule